// File: doc/BRIEF.md
# Period and High-Time Accumulator

This block measures a digital input against a free-running 16-bit timebase that is supplied from outside. In period mode it adds up the time from one rising edge of the input to the next. In high-time mode it adds up only the time the input stays high. After a programmed number of periods it publishes the total as a 16-bit result and an 8-bit extension, pulses `done`, and clears its working sum so that the next block of periods starts from zero.

Long intervals do not wrap the 16-bit timebase unnoticed. While a measurement is running, the block folds the elapsed time into the sum at regular timeout points, a programmed number of ticks apart. Each carry out of the 16-bit sum adds one to the extension byte. The first carry in a block can also raise a one-shot link notification, which tells a neighbouring unit that the sum has overflowed. The same notification can be raised when a block completes.

Top module: `pwacc`

## Requirements
- R1: The input passes through a two-flop synchronizer. An edge that is present on `sig_in` at clock edge k is acted on at clock edge k+2, using the `tbase` value sampled at that edge, and `done`/`link` go high right after edge k+2.
- R2: When `hi_mode`=0 (period mode), the first rising edge after init only records the starting timestamp. Each later rising edge adds the time since the previous rising edge and counts one period.
- R3: When `hi_mode`=1 (high-time mode), a rising edge records the timestamp. The next falling edge adds the high time and counts one period. A falling edge that comes before the first rising edge is ignored.
- R4: Every contribution is the current timestamp minus the stored one, taken modulo 2^16, so a timebase wrap between two samples does not affect the result.
- R5: While a period is open, the elapsed time is folded into the sum each time `tbase` reaches the last timestamp plus `tmo_iv` ticks (a value of 0 means 256 ticks). An interval longer than 65536 ticks is therefore still counted in full. When an edge and a timeout fall in the same cycle, the edge wins.
- R6: When the period count reaches `max_count` (0 means 256), `result` takes the low 16 bits of the sum and `result_ext` takes the number of carries. `done` pulses for exactly one clock. The sum, the count, the carry byte and the sticky overflow flag are all cleared.
- R7: `result` and `result_ext` change only on the clock edge that raises `done`. Between completions they hold their values.
- R8: Each carry out of the 16-bit sum adds one to the extension. The first carry in a block sets a sticky flag and, if `link_en`=1, pulses `link` for one clock. Later carries raise no link until a completion clears the flag.
- R9: When `link_en`=1, `link` also pulses in the same cycle as `done`. When `link_en`=0, `link` stays low.
- R10: An `init` strobe clears the sum, the count, the extension and the sticky flag, and arms the block to wait for a starting edge. A measurement in progress is discarded.
- R11: After reset, `result`, `result_ext`, `done` and `link` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sig_in | input | 1 | Asynchronous signal under measurement |
| tbase | input | 16 | Free-running timebase value |
| init | input | 1 | Start strobe; clears and re-arms the block |
| hi_mode | input | 1 | 1: sum the high time, 0: sum full periods |
| link_en | input | 1 | Enables link pulses on overflow and on completion |
| max_count | input | 8 | Periods per block (0 means 256) |
| tmo_iv | input | 8 | Timeout spacing in ticks (0 means 256) |
| result | output | 16 | Published sum, low 16 bits |
| result_ext | output | 8 | Published carry count |
| done | output | 1 | One-clock completion pulse |
| link | output | 1 | One-clock link/overflow notification |

## Verification
The bench drives `sig_in` on falling clock edges and records the timebase value at the moment it drives the final edge of a block. The block acts on that edge two rising edges later. The bench's `tbase` counter has advanced by three by the next falling edge, which is where a monitor first sees `done`. Every completion therefore checks both the published values and that the recorded timebase equals the stamp plus three. The monitor samples `done` and `link` on each falling edge, away from the edges where they change. It counts link pulses over a block, so the bench can compare the link count and the one-clock width of `done` against values it derives from the summed durations.

// File: rtl/pwacc_pkg.sv
`timescale 1ns/1ps
package pwacc_pkg;
  localparam int unsigned TIME_W_DEF  = 16;
  localparam int unsigned COUNT_W_DEF = 8;
  localparam int unsigned EXT_W_DEF   = 8;
  localparam int unsigned IVAL_W_DEF  = 8;
  localparam int unsigned SYNC_DEF    = 2;

  typedef enum logic {
    MEAS_PERIOD = 1'b0,
    MEAS_HIGH   = 1'b1
  } meas_e;
endpackage

// File: rtl/pwacc_sync_edge.sv
`timescale 1ns/1ps
module pwacc_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop for edge detection
  localparam int unsigned DEPTH = STAGES + 1;
  logic [DEPTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[DEPTH-2:0], din};
  end

  assign rise =  chain_q[STAGES-1] & ~chain_q[STAGES];
  assign fall = ~chain_q[STAGES-1] &  chain_q[STAGES];
endmodule

// File: rtl/pwacc_sched.sv
`timescale 1ns/1ps
module pwacc_sched
  import pwacc_pkg::*;
#(
  parameter int unsigned TIME_W = TIME_W_DEF,
  parameter int unsigned IVAL_W = IVAL_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  meas_e             mode,
  input  logic              rise,
  input  logic              fall,
  input  logic [TIME_W-1:0] tbase,
  input  logic [IVAL_W-1:0] tmo_iv,
  output logic              fold,
  output logic              period_end,
  output logic [TIME_W-1:0] delta
);
  // elapsed ticks, modulo 2^TIME_W
  function automatic logic [TIME_W-1:0] elapsed(input logic [TIME_W-1:0] now,
                                                input logic [TIME_W-1:0] then_t);
    return now - then_t;
  endfunction

  // timeout spacing; a zero setting stands for 2^IVAL_W ticks
  function automatic logic [TIME_W-1:0] span(input logic [IVAL_W-1:0] iv);
    if (iv == '0) return TIME_W'(1) << IVAL_W;
    return TIME_W'(iv);
  endfunction

  logic [TIME_W-1:0] last_q, due_q;
  logic              phase_q;      // 1: waiting for a starting rising edge
  logic              start, edge_fold, tmo_hit;

  assign start     = rise & phase_q;
  assign edge_fold = ((mode == MEAS_HIGH) ? fall : rise) & ~phase_q;
  assign tmo_hit   = ~phase_q & ~edge_fold & (tbase == due_q);
  assign fold       = edge_fold | tmo_hit;
  assign period_end = edge_fold;
  assign delta      = elapsed(tbase, last_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= '0;
      due_q   <= '0;
      phase_q <= 1'b1;
    end else if (init) begin
      phase_q <= 1'b1;
    end else begin
      if (start | fold) begin
        last_q <= tbase;
        due_q  <= tbase + span(tmo_iv);
      end
      if (start) phase_q <= 1'b0;
      if (edge_fold && mode == MEAS_HIGH) phase_q <= 1'b1;
    end
  end

  assert_init_arms_R10: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> phase_q);
  assert_start_from_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phase_q) |-> $past(rise));
  assert_fold_stamps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fold && !init) |=> (last_q == $past(tbase)));
endmodule

// File: rtl/pwacc_sum.sv
`timescale 1ns/1ps
module pwacc_sum
  import pwacc_pkg::*;
#(
  parameter int unsigned TIME_W  = TIME_W_DEF,
  parameter int unsigned COUNT_W = COUNT_W_DEF,
  parameter int unsigned EXT_W   = EXT_W_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               fold,
  input  logic               period_end,
  input  logic [TIME_W-1:0]  delta,
  input  logic [COUNT_W-1:0] max_count,
  input  logic               link_en,
  output logic [TIME_W-1:0]  result,
  output logic [EXT_W-1:0]   result_ext,
  output logic               done,
  output logic               link
);
  // sum with the carry out in the top bit
  function automatic logic [TIME_W:0] add_carry(input logic [TIME_W-1:0] a,
                                                input logic [TIME_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [TIME_W-1:0]  acc_q, res_q;
  logic [EXT_W-1:0]   ext_q, rext_q, ext_nx;
  logic [COUNT_W-1:0] cnt_q, cnt_nx;
  logic               sticky_q, done_q, link_q;
  logic [TIME_W:0]    sum_w;
  logic               carry, complete, ovf_link;

  assign sum_w    = add_carry(acc_q, delta);
  assign carry    = fold & sum_w[TIME_W];
  assign ext_nx   = ext_q + EXT_W'(carry);
  assign cnt_nx   = cnt_q + COUNT_W'(1);
  assign complete = period_end & (cnt_nx == max_count);
  assign ovf_link = carry & ~sticky_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0; ext_q <= '0; cnt_q <= '0; sticky_q <= 1'b0;
      res_q <= '0; rext_q <= '0; done_q <= 1'b0; link_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      link_q <= 1'b0;
      if (init) begin
        acc_q <= '0; ext_q <= '0; cnt_q <= '0; sticky_q <= 1'b0;
      end else if (fold) begin
        if (complete) begin
          res_q    <= sum_w[TIME_W-1:0];
          rext_q   <= ext_nx;
          acc_q    <= '0;
          ext_q    <= '0;
          cnt_q    <= '0;
          sticky_q <= 1'b0;
          done_q   <= 1'b1;
          link_q   <= link_en;
        end else begin
          acc_q <= sum_w[TIME_W-1:0];
          ext_q <= ext_nx;
          if (period_end) cnt_q <= cnt_nx;
          if (carry) sticky_q <= 1'b1;
          link_q <= link_en & ovf_link;
        end
      end
    end
  end

  assign result     = res_q;
  assign result_ext = rext_q;
  assign done       = done_q;
  assign link       = link_q;

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_cleared_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cnt_q == '0 && acc_q == '0 && ext_q == '0 && !sticky_q));
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(result) && $stable(result_ext)));
  assert_link_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    link |-> $past(link_en));
  assert_sticky_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fold && sticky_q && !complete && !init) |=> !link);
endmodule

// File: rtl/pwacc.sv
`timescale 1ns/1ps
module pwacc
  import pwacc_pkg::*;
#(
  parameter int unsigned TIME_W  = TIME_W_DEF,
  parameter int unsigned COUNT_W = COUNT_W_DEF,
  parameter int unsigned EXT_W   = EXT_W_DEF,
  parameter int unsigned IVAL_W  = IVAL_W_DEF,
  parameter int unsigned SYNC_N  = SYNC_DEF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sig_in,
  input  logic [TIME_W-1:0]  tbase,
  input  logic               init,
  input  logic               hi_mode,
  input  logic               link_en,
  input  logic [COUNT_W-1:0] max_count,
  input  logic [IVAL_W-1:0]  tmo_iv,
  output logic [TIME_W-1:0]  result,
  output logic [EXT_W-1:0]   result_ext,
  output logic               done,
  output logic               link
);
  logic              rise_w, fall_w, fold_w, pend_w;
  logic [TIME_W-1:0] delta_w;
  meas_e             mode_w;

  assign mode_w = meas_e'(hi_mode);

  pwacc_sync_edge #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(sig_in), .rise(rise_w), .fall(fall_w)
  );

  pwacc_sched #(.TIME_W(TIME_W), .IVAL_W(IVAL_W)) u_sched (
    .clk(clk), .rst_n(rst_n), .init(init), .mode(mode_w),
    .rise(rise_w), .fall(fall_w), .tbase(tbase), .tmo_iv(tmo_iv),
    .fold(fold_w), .period_end(pend_w), .delta(delta_w)
  );

  pwacc_sum #(.TIME_W(TIME_W), .COUNT_W(COUNT_W), .EXT_W(EXT_W)) u_sum (
    .clk(clk), .rst_n(rst_n), .init(init), .fold(fold_w),
    .period_end(pend_w), .delta(delta_w), .max_count(max_count),
    .link_en(link_en), .result(result), .result_ext(result_ext),
    .done(done), .link(link)
  );
endmodule

// File: tb/tb_pwacc.sv
`timescale 1ns/1ps
module tb_pwacc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sig_in = 1'b0;
  logic [15:0] tbase = 16'hFFC0;
  logic        init = 1'b0;
  logic        hi_mode = 1'b0;
  logic        link_en = 1'b0;
  logic [7:0]  max_count = 8'd1;
  logic [7:0]  tmo_iv = 8'd10;
  logic [15:0] result;
  logic [7:0]  result_ext;
  logic        done, link;

  int checks = 0, errors = 0;
  int done_cnt = 0, link_cnt = 0, dbl_done = 0;
  logic [15:0] rec_res, rec_t, t_mark;
  logic [7:0]  rec_ext;
  logic        rec_link, prev_done = 1'b0;
  bit          finished = 1'b0;
  int          hv [0:255];
  int          lv [0:255];

  pwacc dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .tbase(tbase), .init(init),
    .hi_mode(hi_mode), .link_en(link_en), .max_count(max_count), .tmo_iv(tmo_iv),
    .result(result), .result_ext(result_ext), .done(done), .link(link)
  );

  always #2 clk = ~clk;
  always @(posedge clk) tbase <= tbase + 16'd1;

  // monitor samples on falling edges
  always @(negedge clk) begin
    if (done) begin
      done_cnt <= done_cnt + 1;
      rec_res  <= result;
      rec_ext  <= result_ext;
      rec_t    <= tbase;
      rec_link <= link;
      if (prev_done) dbl_done <= dbl_done + 1;
    end
    if (link) link_cnt <= link_cnt + 1;
    prev_done <= done;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    sig_in = v;
    t_mark = tbase;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_init();
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    @(negedge clk);
  endtask

  // one measurement block built from hv/lv; expected values computed here
  task automatic run_block(input bit mode, input int mc, input bit le, input int iv);
    longint total = 0;
    int d0, l0, exp_links;
    logic [15:0] edge_t;
    hi_mode = mode; link_en = le; max_count = mc[7:0]; tmo_iv = iv[7:0];
    pulse_init();
    hold(1'b0, 3);
    d0 = done_cnt; l0 = link_cnt;
    for (int i = 0; i < mc; i++) begin
      hold(1'b1, hv[i]);
      if (mode) edge_t = t_mark;
      hold(1'b0, lv[i]);
      if (mode) edge_t = t_mark;
      total += mode ? hv[i] : (hv[i] + lv[i]);
    end
    if (!mode) begin
      hold(1'b1, 4);
      edge_t = t_mark;
      hold(1'b0, 8);
    end else begin
      hold(1'b0, 8);
    end
    exp_links = le ? (((total >= 65536) ? 1 : 0) + 1) : 0;
    chk("R6 done count", done_cnt - d0, 1);
    chk(mode ? "R3/R4 result" : "R2/R4 result", rec_res, total & 16'hFFFF);
    chk("R8 extension", rec_ext, (total >> 16) & 8'hFF);
    chk("R1 done timing", rec_t, 16'(edge_t + 16'd3));
    chk("R9 link with done", rec_link, le);
    chk("R8/R9 link count", link_cnt - l0, exp_links);
  endtask

  initial begin
    repeat (199000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 result", result, 0);
    chk("R11 ext", result_ext, 0);
    chk("R11 done", done, 0);
    chk("R11 link", link, 0);

    // R10: partial measurement abandoned by init inside run_block
    hi_mode = 1'b0; max_count = 8'd3; pulse_init();
    hold(1'b0, 3);
    for (int i = 0; i < 2; i++) begin hold(1'b1, 3); hold(1'b0, 4); end
    hold(1'b0, 6);
    chk("R10 no done on partial", done_cnt, 0);
    hv[0] = 5; lv[0] = 6;
    run_block(1'b0, 1, 1'b0, 4);   // R10: only post-init time counted

    // near-exhaustive sweep over mode, count, link, interval (R2 R3 R5 R9)
    for (int m = 0; m < 2; m++) begin
      for (int mc = 1; mc <= 5; mc++) begin
        for (int i = 0; i < mc; i++) begin
          hv[i] = 2 + ((i * 5 + mc * 3 + m) % 8);
          lv[i] = 2 + ((i * 3 + mc + 2 * m) % 7);
        end
        run_block(m[0], mc, mc[0], (mc == 3) ? 0 : (2 + mc));
      end
    end

    // R6: max_count 0 means 256 periods, high-time mode
    for (int i = 0; i < 256; i++) begin hv[i] = 2 + (i % 3); lv[i] = 2; end
    run_block(1'b1, 256, 1'b1, 5);

    // R5/R8: long periods, two carries, sticky flag, interval 0 = 256 ticks
    hv[0] = 1000; lv[0] = 65000; hv[1] = 1000; lv[1] = 64500;
    run_block(1'b0, 2, 1'b1, 0);

    chk("R6 done one clock wide", dbl_done, 0);
    chk("R7 result held", result, rec_res);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule